// File: doc/BRIEF.md
# Multi-Mode 8-Bit PWM Timer

This block is an 8-bit timer/counter with one compare channel and a built-in clock divider. Four counting modes are available: a free-running up counter, a counter that restarts after reaching the compare value, a single-slope PWM and a dual-slope (up/down) PWM. A single output pin is driven from compare events. In the non-PWM modes the pin can toggle, clear or set on a match. In the PWM modes the pin produces a non-inverted or an inverted duty cycle.

Software-side logic writes the mode, divider selection and output action together through one configuration strobe, and writes the compare value through a second strobe. In the PWM modes a new compare value is staged in a holding register. It only reaches the comparator at the top of the count, so a period is never cut short or doubled. A force strobe applies the configured pin action at once, but only in the non-PWM modes. Overflow and compare events are kept in two sticky flags, and each flag has its own clear input. Every pin is a plain level or strobe; the block has no streaming data path and so no valid/ready handshake.

Top module: `pwm_timer8`

## Requirements
- R1: The divider select (`cfg_clk_sel`) stops the count at codes 0, 6 and 7. Codes 1..5 give one count step per 1, 8, 64, 256 or 1024 clocks. The internal divider is a 10-bit counter that runs freely from reset and steps once per clock. A count step occurs in the clock whose divider low 0, 3, 6, 8 or 10 bits are all ones.
- R2: In mode code 0 (free-running), each step adds one to the count, and the count rolls from 255 to 0. The step that leaves 255 raises the overflow flag.
- R3: In mode code 1 (restart on compare), a step taken while the count equals the active compare value loads 0 instead of count+1. A step taken from 255 also raises the overflow flag.
- R4: In mode code 2 (single-slope PWM), the count rolls from 255 to 0 with overflow on the roll. With output action code 2, the pin goes high on the step that leaves 255 and goes low on a compare step. With code 3 the levels are reversed. Codes 0 and 1 leave the pin unchanged. The roll takes priority when both events fall on the same step.
- R5: In mode code 3 (dual-slope PWM), the count climbs to 255 and then descends to 0, which gives the sequence 254, 255, 254 … 1, 0, 1. Overflow is raised on the step that turns at 0. With output code 2, a compare step while climbing drives the pin low and one while descending drives it high. Code 3 reverses this.
- R6: In the PWM modes (codes 2 and 3), a compare write only loads a holding register. The holding value becomes active on the step taken from count 255. In modes 0 and 1 a compare write changes the active value on the next clock.
- R7: A force pulse in mode 0 or 1 applies the output action at once: code 1 toggles, 2 drives low, 3 drives high, 0 holds. It does not raise a flag or change the count. In modes 2 and 3 a force pulse has no effect.
- R8: In mode 2 with active compare value 255 and output code 2, the pin stays high once it has gone high. With output code 3 it stays low.
- R9: Each flag stays set until a one is applied to its clear input. A new event in the same clock as a clear leaves the flag set.
- R10: After reset: count 0, pin low, both flags low, mode 0, divider stopped, output code 0, compare value 0.
- R11: In modes 0 and 1, a compare step applies the output action (code 1 toggles, 2 drives low, 3 drives high, 0 holds). A compare step together with a force pulse applies the action only once.
- R12: In every mode, a step taken while the count equals the active compare value raises the compare flag. No other event raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads mode, divider select and output code |
| cfg_mode | input | 2 | Mode code 0..3 |
| cfg_clk_sel | input | 3 | Divider select |
| cfg_out_mode | input | 2 | Output action code |
| cmp_we | input | 1 | Compare write strobe |
| cmp_data | input | 8 | Compare value to write |
| force_match | input | 1 | Force-compare pulse |
| ovf_clr | input | 1 | Clears the overflow flag |
| cmp_clr | input | 1 | Clears the compare flag |
| count | output | 8 | Counter value |
| wave_out | output | 1 | Waveform pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
Directed patterns come first. A stopped divider and two slow divider settings show the step rate. A steady compare of 255 in single-slope PWM separates correct roll-over priority from match-first logic. A compare write at mid-period in PWM separates buffered updating from direct updating, because the pin stays high past the new threshold until the next roll. Force pulses with a stopped counter separate the output action from any flag or count side effect. A long random run then mixes mode, divider, compare, force and clear traffic. It compares count, pin and both flags every clock against a reference built from the requirements.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_CTC   = 2'd1,
    MODE_FAST  = 2'd2,
    MODE_DUAL  = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    OUT_HOLD   = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_CLEAR  = 2'd2,
    OUT_SET    = 2'd3
  } oact_e;

  function automatic logic mode_is_pwm(tmode_e m);
    return (m == MODE_FAST) || (m == MODE_DUAL);
  endfunction

  function automatic logic apply_action(oact_e a, logic cur);
    case (a)
      OUT_TOGGLE: return ~cur;
      OUT_CLEAR:  return 1'b0;
      OUT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/timer8_prescale.sv
module timer8_prescale #(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int TAP1 = 3;
  localparam int TAP2 = 6;
  localparam int TAP3 = 8;
  localparam int TAP4 = PSC_W;

  logic [PSC_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    case (sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &div_q[TAP1-1:0];
      3'd3:    tick = &div_q[TAP2-1:0];
      3'd4:    tick = &div_q[TAP3-1:0];
      3'd5:    tick = &div_q[TAP4-1:0];
      default: tick = 1'b0;
    endcase
  end

  a_r1_div8_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd2 && tick) |=> !tick);

endmodule

// File: rtl/timer8_counter.sv
module timer8_counter
  import timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tmode_e           mode,
  input  logic             match,
  output logic [CNT_W-1:0] count,
  output logic             down,
  output logic             wrap_evt,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CMIN = '0;

  logic             at_max, at_min, nxt_down;
  logic [CNT_W-1:0] nxt;

  assign at_max = (count == CMAX);
  assign at_min = (count == CMIN);

  always_comb begin
    nxt      = count + 1'b1;
    nxt_down = 1'b0;
    case (mode)
      MODE_CTC:  nxt = match ? CMIN : count + 1'b1;
      MODE_DUAL: begin
        if (!down) begin
          nxt      = at_max ? count - 1'b1 : count + 1'b1;
          nxt_down = at_max;
        end else begin
          nxt      = at_min ? count + 1'b1 : count - 1'b1;
          nxt_down = !at_min;
        end
      end
      default:   nxt = count + 1'b1;
    endcase
  end

  assign wrap_evt = tick && at_max && !down;
  assign ovf_evt  = (mode == MODE_DUAL) ? (tick && down && at_min) : (tick && at_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      down  <= 1'b0;
    end else begin
      if (tick) count <= nxt;
      if (mode != MODE_DUAL) down <= 1'b0;
      else if (tick)         down <= nxt_down;
    end
  end

  a_r1_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  a_r2_roll_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FREE && tick && count == CMAX) |=> count == CMIN);
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CTC && match) |=> count == CMIN);
  a_r5_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DUAL && tick && at_max && !down) |=> (count == CMAX - 1'b1) && down);

endmodule

// File: rtl/timer8_compare.sv
module timer8_compare
  import timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmode_e           mode,
  input  logic             tick,
  input  logic             wrap_evt,
  input  logic [CNT_W-1:0] count,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_data,
  output logic [CNT_W-1:0] cmp_act,
  output logic             match
);
  logic             pwm, upd;
  logic [CNT_W-1:0] hold_q;

  assign pwm   = mode_is_pwm(mode);
  assign upd   = pwm && wrap_evt;
  assign match = tick && (count == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
      hold_q  <= '0;
    end else begin
      if (cmp_we) hold_q <= cmp_data;
      if (cmp_we && !pwm) cmp_act <= cmp_data;
      else if (upd)       cmp_act <= hold_q;
    end
  end

  a_r6_buffered_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !wrap_evt) |=> $stable(cmp_act));
  a_r6_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && cmp_we) |=> cmp_act == $past(cmp_data));

endmodule

// File: rtl/timer8_wave.sv
module timer8_wave
  import timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmode_e           mode,
  input  oact_e            act,
  input  logic             match,
  input  logic             wrap_evt,
  input  logic             down,
  input  logic             force_in,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             wave
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic nxt;

  always_comb begin
    nxt = wave;
    case (mode)
      MODE_FAST: begin
        if (wrap_evt) begin
          if (act == OUT_CLEAR)    nxt = 1'b1;
          else if (act == OUT_SET) nxt = 1'b0;
        end else if (match) begin
          if (act == OUT_CLEAR)    nxt = 1'b0;
          else if (act == OUT_SET) nxt = 1'b1;
        end
      end
      MODE_DUAL: begin
        if (match) begin
          if (act == OUT_CLEAR)    nxt = down;
          else if (act == OUT_SET) nxt = !down;
        end
      end
      default: begin
        if (match || force_in) nxt = apply_action(act, wave);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= nxt;
  end

  a_r8_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && act == OUT_CLEAR && cmp_act == CMAX && wave) |=> wave);
  a_r7_force_ignored_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_pwm(mode) && !match && !wrap_evt) |=> $stable(wave));

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import timer8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [2:0]       cfg_clk_sel,
  input  logic [1:0]       cfg_out_mode,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_data,
  input  logic             force_match,
  input  logic             ovf_clr,
  input  logic             cmp_clr,
  output logic [CNT_W-1:0] count,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  tmode_e           mode_q;
  oact_e            act_q;
  logic [2:0]       sel_q;
  logic             tick, match, down, wrap_evt, ovf_evt, force_eff;
  logic [CNT_W-1:0] cmp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      act_q  <= OUT_HOLD;
      sel_q  <= 3'd0;
    end else if (cfg_we) begin
      mode_q <= tmode_e'(cfg_mode);
      act_q  <= oact_e'(cfg_out_mode);
      sel_q  <= cfg_clk_sel;
    end
  end

  assign force_eff = force_match && !mode_is_pwm(mode_q);

  timer8_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .tick(tick)
  );

  timer8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .match(match),
    .count(count), .down(down), .wrap_evt(wrap_evt), .ovf_evt(ovf_evt)
  );

  timer8_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick), .wrap_evt(wrap_evt),
    .count(count), .cmp_we(cmp_we), .cmp_data(cmp_data),
    .cmp_act(cmp_act), .match(match)
  );

  timer8_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .act(act_q), .match(match),
    .wrap_evt(wrap_evt), .down(down), .force_in(force_eff), .cmp_act(cmp_act),
    .wave(wave_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_evt | (ovf_flag & ~ovf_clr);
      cmp_flag <= match   | (cmp_flag & ~cmp_clr);
    end
  end

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  a_r9_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !cmp_clr) |=> cmp_flag);
  a_r12_cmp_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_flag && !match) |=> !cmp_flag);
  a_r7_force_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (force_match && !tick) |=> $stable(count));

endmodule

// File: tb/tb_pwm_timer8.sv
module tb_pwm_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [2:0] cfg_clk_sel = 3'd0;
  logic [1:0] cfg_out_mode = 2'd0;
  logic       cmp_we = 1'b0;
  logic [7:0] cmp_data = 8'd0;
  logic       force_match = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       cmp_clr = 1'b0;
  logic [7:0] count;
  logic       wave_out, ovf_flag, cmp_flag;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_timer8 dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_clk_sel(cfg_clk_sel), .cfg_out_mode(cfg_out_mode), .cmp_we(cmp_we),
    .cmp_data(cmp_data), .force_match(force_match), .ovf_clr(ovf_clr),
    .cmp_clr(cmp_clr), .count(count), .wave_out(wave_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  // reference state built from the requirements
  logic [9:0] m_psc;
  logic [7:0] m_cnt, m_act, m_hold;
  logic       m_down, m_wave, m_ovf, m_cmpf;
  logic [1:0] m_mode, m_com;
  logic [2:0] m_sel;

  function automatic logic ref_step(logic [2:0] s, logic [9:0] p);
    case (s)
      3'd1: return 1'b1;
      3'd2: return p[2:0] == 3'h7;
      3'd3: return p[5:0] == 6'h3f;
      3'd4: return p[7:0] == 8'hff;
      3'd5: return p == 10'h3ff;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_action(logic [1:0] c, logic cur);
    case (c)
      2'd1: return ~cur;
      2'd2: return 1'b0;
      2'd3: return 1'b1;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : ref_model
    logic tk, mt, roll, ov;
    if (!rst_n) begin
      m_psc <= '0; m_cnt <= '0; m_act <= '0; m_hold <= '0; m_down <= 1'b0;
      m_wave <= 1'b0; m_ovf <= 1'b0; m_cmpf <= 1'b0;
      m_mode <= 2'd0; m_com <= 2'd0; m_sel <= 3'd0;
    end else begin
      tk   = ref_step(m_sel, m_psc);
      mt   = tk && (m_cnt == m_act);
      roll = tk && (m_cnt == 8'hff) && !m_down;
      m_psc <= m_psc + 1'b1;
      // count and direction
      if (m_mode == 2'd3) begin
        ov = tk && m_down && (m_cnt == 8'd0);
        if (tk) begin
          if (!m_down) begin
            if (m_cnt == 8'hff) begin m_cnt <= 8'hfe; m_down <= 1'b1; end
            else m_cnt <= m_cnt + 1'b1;
          end else begin
            if (m_cnt == 8'd0) begin m_cnt <= 8'd1; m_down <= 1'b0; end
            else m_cnt <= m_cnt - 1'b1;
          end
        end
      end else begin
        ov = tk && (m_cnt == 8'hff);
        m_down <= 1'b0;
        if (tk) m_cnt <= (m_mode == 2'd1 && mt) ? 8'd0 : m_cnt + 1'b1;
      end
      // pin
      case (m_mode)
        2'd2: begin
          if (roll) begin
            if (m_com == 2'd2) m_wave <= 1'b1;
            else if (m_com == 2'd3) m_wave <= 1'b0;
          end else if (mt) begin
            if (m_com == 2'd2) m_wave <= 1'b0;
            else if (m_com == 2'd3) m_wave <= 1'b1;
          end
        end
        2'd3: if (mt) begin
          if (m_com == 2'd2) m_wave <= m_down;
          else if (m_com == 2'd3) m_wave <= !m_down;
        end
        default: if (mt || force_match) m_wave <= ref_action(m_com, m_wave);
      endcase
      // compare value
      if (cmp_we) m_hold <= cmp_data;
      if (cmp_we && !m_mode[1]) m_act <= cmp_data;
      else if (m_mode[1] && roll) m_act <= m_hold;
      // flags
      m_ovf  <= ov | (m_ovf & ~ovf_clr);
      m_cmpf <= mt | (m_cmpf & ~cmp_clr);
      if (cfg_we) begin
        m_mode <= cfg_mode; m_com <= cfg_out_mode; m_sel <= cfg_clk_sel;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string cnt_tag(logic [1:0] m);
    case (m)
      2'd0: return "R2 count";
      2'd1: return "R3 count";
      2'd2: return "R4 count";
      default: return "R5 count";
    endcase
  endfunction

  function automatic string pin_tag(logic [1:0] m);
    case (m)
      2'd2: return "R4 pin";
      2'd3: return "R5 pin";
      default: return "R11 pin";
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    chk(cnt_tag(m_mode), count, m_cnt);
    chk(pin_tag(m_mode), wave_out, m_wave);
    chk("R9 overflow flag", ovf_flag, m_ovf);
    chk("R12 compare flag", cmp_flag, m_cmpf);
  endtask

  task automatic configure(logic [1:0] md, logic [2:0] sl, logic [1:0] om);
    cfg_mode = md; cfg_clk_sel = sl; cfg_out_mode = om; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic write_cmp(logic [7:0] v);
    cmp_data = v; cmp_we = 1'b1;
    step();
    cmp_we = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] c0;
    logic       w0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 count", count, 0);
    chk("R10 pin", wave_out, 0);
    chk("R10 overflow flag", ovf_flag, 0);
    chk("R10 compare flag", cmp_flag, 0);
    run(20);
    chk("R1 stopped after reset", count, 0);

    // R2 free-running, divide by one
    configure(2'd0, 3'd1, 2'd0);
    run(300);
    chk("R2 overflow raised", ovf_flag, 1);

    // R1 divider rates
    configure(2'd0, 3'd2, 2'd0);
    c0 = count; run(64);
    chk("R1 divide by 8", 8'(count - c0), 8);
    configure(2'd0, 3'd3, 2'd0);
    c0 = count; run(128);
    chk("R1 divide by 64", 8'(count - c0), 2);
    configure(2'd0, 3'd0, 2'd0);
    c0 = count; run(50);
    chk("R1 stopped", count, c0);

    // R9 sticky flag then clear
    chk("R9 flag kept", ovf_flag, 1);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R9 flag cleared", ovf_flag, 0);

    // R7 force in a non-PWM mode with the counter stopped
    configure(2'd0, 3'd0, 2'd1);
    cmp_clr = 1'b1; step(); cmp_clr = 1'b0;
    w0 = wave_out; c0 = count;
    force_match = 1'b1; step(); force_match = 1'b0;
    chk("R7 force toggles", wave_out, !w0);
    chk("R7 force keeps count", count, c0);
    chk("R7 force raises no flag", cmp_flag, 0);
    configure(2'd0, 3'd0, 2'd3);
    force_match = 1'b1; step(); force_match = 1'b0;
    chk("R7 force sets", wave_out, 1);

    // R3 restart on compare
    write_cmp(8'd20);
    configure(2'd1, 3'd1, 2'd1);
    run(300);
    for (int i = 0; i < 100; i++) begin
      step();
      chk("R3 bounded by compare", int'(count <= 8'd20), 1);
    end

    // R8 steady high in single-slope PWM
    configure(2'd0, 3'd0, 2'd0);
    write_cmp(8'd255);
    configure(2'd2, 3'd1, 2'd2);
    run(260);
    for (int i = 0; i < 300; i++) begin
      step();
      chk("R8 constant level", wave_out, 1);
    end

    // R6 buffered compare in PWM
    while (count !== 8'd100) step();
    write_cmp(8'd200);
    while (count !== 8'd210) step();
    chk("R6 old value still active", wave_out, 1);
    while (count !== 8'd0) step();
    while (count !== 8'd210) step();
    chk("R6 new value after roll", wave_out, 0);
    w0 = wave_out;
    force_match = 1'b1; step(); force_match = 1'b0;
    chk("R7 force ignored in PWM", wave_out, w0);

    // R5 dual-slope
    configure(2'd0, 3'd0, 2'd0);
    write_cmp(8'd100);
    ovf_clr = 1'b1;
    configure(2'd3, 3'd1, 2'd2);
    ovf_clr = 1'b0;
    run(1100);
    chk("R5 overflow at bottom", ovf_flag, 1);

    // inverted single-slope with small compare
    configure(2'd2, 3'd1, 2'd3);
    write_cmp(8'd0);
    run(600);

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cfg_we = (r[7:0] == 8'd0);
      cfg_mode = 2'($urandom % 4);
      cfg_clk_sel = (r[9:8] == 2'd0) ? 3'($urandom % 8) : ((r[10]) ? 3'd1 : 3'd2);
      cfg_out_mode = 2'($urandom % 4);
      cmp_we = (r[15:11] == 5'd0);
      cmp_data = r[11] ? 8'($urandom) : (r[12] ? 8'd255 : 8'd0);
      force_match = (r[20:16] == 5'd3);
      ovf_clr = (r[25:21] == 5'd7);
      cmp_clr = (r[30:26] == 5'd9);
      step();
    end
    cfg_we = 1'b0; cmp_we = 1'b0; force_match = 1'b0; ovf_clr = 1'b0; cmp_clr = 1'b0;
    run(10);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule